// File: doc/BRIEF.md
# FP8 to IEEE Float Widening Decoder

This block is a purely combinational converter. It takes an 8-bit minifloat code and expands it into an IEEE binary16 or binary32 bit pattern. The split between exponent and mantissa in the byte is fixed by the parameter `WE`, which gives the exponent width; the mantissa width is `7 - WE`. The value never loses precision on the way out, so the block does no rounding.

A mode input chooses between two ways of reading the byte. In IEEE-like mode the exponent bias is `2^(WE-1)-1`. An all-ones exponent field then means infinity or NaN, and code 0x80 means negative zero. In single-NaN mode the bias is one larger, 0x80 is the only NaN, and every other code is a finite number. A second input picks binary32 output or binary16 output. Binary16 output sits in the low half of the result word.

Minifloat subnormals are normalised using the position of their leading one. The exponent is then rebiased to the target format. When the value falls below the binary16 normal range, the block produces a binary16 subnormal.

Top module: `fp8_widen`

## Requirements
- R1: Code 0x00 produces an all-zero result in every mode and output format.
- R2: In single-NaN mode (`nonz_mode_i`=1), code 0x80 produces 0x7F800001 for binary32 and 0x00007C01 for binary16.
- R3: In IEEE-like mode (`nonz_mode_i`=0), code 0x80 produces negative zero: 0x80000000 for binary32 and 0x00008000 for binary16.
- R4: In IEEE-like mode, an all-ones exponent field (bits 6 down to 7-WE) with a zero mantissa produces infinity with the input sign. With a non-zero mantissa it produces the positive canonical NaN of R2.
- R5: With WE=5, IEEE-like mode and binary16 output, every finite code produces the input byte shifted left by eight bits.
- R6: A code with a zero exponent field and a non-zero mantissa decodes to the exact value `m * 2^(1-bias-WM)`, normalised in the target format. The bias is `2^(WE-1)-1`, plus 1 in single-NaN mode.
- R7: If the exact value lies below 2^-14 and the output is binary16 (`single_i`=0), the result is the binary16 subnormal with mantissa `value * 2^24`.
- R8: A code with a non-zero exponent field e decodes to the exact value `(1 + m/2^WM) * 2^(e-bias)`, for every code not covered by R2 to R4.
- R9: For binary16 output, result bits 31:16 are zero. The sign of every finite non-zero result sits in bit 15 (binary16) or bit 31 (binary32) and equals input bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| code_i | input | 8 | Minifloat code: sign in bit 7, exponent field above the mantissa |
| nonz_mode_i | input | 1 | 1 = single-NaN mode (no negative zero, bias one larger), 0 = IEEE-like mode |
| single_i | input | 1 | 1 = binary32 result, 0 = binary16 result in bits 15:0 |
| value_o | output | 32 | Widened floating-point pattern |

## Verification
The block holds no state, so a fault shows at the port on the same input pattern that reaches it. A wrong leading-one position or exponent offset gives a result that is off by a power of two for a whole band of codes. A misplaced special-case decision turns one particular code into a wrong zero, infinity or NaN. Every one of the 256 codes is applied under both modes and both output formats. The expected pattern is built from the exact real value of each code, so a single mis-decoded code is reported.

// File: rtl/fp8_widen.sv
module fp8_widen #(
  parameter int WE = 4
) (
  input  logic [7:0]  code_i,
  input  logic        nonz_mode_i,
  input  logic        single_i,
  output logic [31:0] value_o
);
  localparam int WM       = 7 - WE;
  localparam int HALF_OFS = 16 - 2 ** (WE - 1) + 1;
  localparam int SGL_OFS  = 128 - 2 ** (WE - 1) + 1;

  logic          sgn;
  logic [WE-1:0] efld;
  logic [WM-1:0] mfld;
  logic [WM-1:0] mnorm;
  logic          shortcut;
  int            lead;
  int            ebase;

  assign sgn  = code_i[7];
  assign efld = code_i[6:WM];
  assign mfld = code_i[WM-1:0];

  always_comb begin
    lead = 0;
    for (int i = 0; i < WM; i++)
      if (mfld[i]) lead = i;
  end

  assign mnorm = (efld == '0) ? WM'(mfld << (WM - lead)) : mfld;
  assign ebase = (efld == '0) ? 1 - (WM - lead) : int'(efld);

  generate
    if (WE == 5) begin : g_pass
      assign shortcut = !nonz_mode_i && !single_i;
    end else begin : g_nopass
      assign shortcut = 1'b0;
    end
  endgenerate

  function automatic logic [31:0] pack(input logic s, input int ex,
                                       input logic [WM-1:0] mn,
                                       input int mw, input int ew);
    logic [31:0] f;
    int          e;
    f = 32'(mn) << (mw - WM);
    e = ex;
    if (e <= 0) begin
      f = (f | (32'd1 << mw)) >> (1 - e);
      e = 0;
    end
    return (32'(s) << (mw + ew)) | ((32'(e) & ((32'd1 << ew) - 1)) << mw)
         | (f & ((32'd1 << mw) - 1));
  endfunction

  always_comb begin
    if (code_i == 8'h00)
      value_o = '0;
    else if (code_i == 8'h80)
      value_o = nonz_mode_i ? (single_i ? 32'h7F80_0001 : 32'h0000_7C01)
                            : (single_i ? 32'h8000_0000 : 32'h0000_8000);
    else if (!nonz_mode_i && efld == '1)
      value_o = (mfld != '0) ? (single_i ? 32'h7F80_0001 : 32'h0000_7C01)
                             : (single_i ? {sgn, 31'h7F80_0000}
                                         : {16'h0, sgn, 15'h7C00});
    else if (shortcut)
      value_o = {16'h0, code_i, 8'h00};
    else if (single_i)
      value_o = pack(sgn, ebase + SGL_OFS - int'(nonz_mode_i) - 1, mnorm, 23, 8);
    else
      value_o = pack(sgn, ebase + HALF_OFS - int'(nonz_mode_i) - 1, mnorm, 10, 5);
  end
endmodule

// File: rtl/fp8_widen_chk.sv
module fp8_widen_chk #(
  parameter int WE = 4
) (
  input logic [7:0]  code_i,
  input logic        nonz_mode_i,
  input logic        single_i,
  input logic [31:0] value_o
);
  localparam int WM = 7 - WE;
  logic nan_in;
  assign nan_in = !nonz_mode_i && (code_i[6:WM] == '1) && (code_i[WM-1:0] != '0);

  always_comb begin
    if (!$isunknown({code_i, nonz_mode_i, single_i})) begin
      a_r1_zero_in: assert (code_i != 8'h00 || value_o == 32'h0);
      a_r2_single_nan: assert (!(nonz_mode_i && code_i == 8'h80) ||
                               value_o == (single_i ? 32'h7F80_0001 : 32'h0000_7C01));
      a_r3_neg_zero: assert (!(!nonz_mode_i && code_i == 8'h80) ||
                             value_o == (single_i ? 32'h8000_0000 : 32'h0000_8000));
      a_r9_upper_clear: assert (single_i || value_o[31:16] == 16'h0);
      a_r9_sign_place: assert (code_i == 8'h00 || code_i == 8'h80 || nan_in ||
                               (single_i ? value_o[31] : value_o[15]) == code_i[7]);
      if (WE == 5) begin
        a_r5_passthru: assert (nonz_mode_i || single_i || nan_in || code_i == 8'h80 ||
                               value_o == {16'h0, code_i, 8'h00});
      end
    end
  end
endmodule

bind fp8_widen fp8_widen_chk #(.WE(WE)) u_chk (
  .code_i(code_i), .nonz_mode_i(nonz_mode_i), .single_i(single_i), .value_o(value_o)
);

// File: tb/fp8_widen_test.sv
module fp8_widen_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  code;
    logic        nz;
    logic        sgl;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } item_t;

  logic        clk = 0;
  logic        rst = 1;
  logic [7:0]  code = 0;
  logic        nz = 0;
  logic        sgl = 0;
  logic [31:0] res_a, res_b;
  item_t       q[$];
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fp8_widen #(.WE(4)) uut (.code_i(code), .nonz_mode_i(nz), .single_i(sgl), .value_o(res_a));
  fp8_widen #(.WE(5)) uut_b (.code_i(code), .nonz_mode_i(nz), .single_i(sgl), .value_o(res_b));

  function automatic real p2(input int k);
    real r = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) r = r * 2.0;
    else for (int i = 0; i < -k; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [31:0] ref_model(input int we, input logic [7:0] c,
                                            input logic n, input logic s32);
    int   wm = 7 - we;
    int   ef = (c >> wm) & ((1 << we) - 1);
    int   mf = c & ((1 << wm) - 1);
    int   bias = (1 << (we - 1)) - 1 + int'(n);
    real  av;
    logic [63:0] d;
    int   dexp;
    logic sg = c[7];
    if (c == 8'h00) return 32'h0;
    if (c == 8'h80) return n ? (s32 ? 32'h7F80_0001 : 32'h7C01)
                             : (s32 ? 32'h8000_0000 : 32'h8000);
    if (!n && ef == (1 << we) - 1)
      return (mf != 0) ? (s32 ? 32'h7F80_0001 : 32'h7C01)
                       : (s32 ? {sg, 31'h7F80_0000} : {16'h0, sg, 15'h7C00});
    if (ef == 0) av = real'(mf) * p2(1 - bias - wm);
    else av = (1.0 + real'(mf) * p2(-wm)) * p2(ef - bias);
    d = $realtobits(av);
    dexp = int'(d[62:52]);
    if (s32) return {sg, 8'(dexp - 1023 + 127), d[51:29]};
    if (av >= p2(-14)) return {16'h0, sg, 5'(dexp - 1023 + 15), d[51:42]};
    return {16'h0, sg, 5'h0, 10'($rtoi(av * p2(24)))};
  endfunction

  function automatic string tag(input int we, input logic [7:0] c, input logic n, input logic s32);
    int wm = 7 - we;
    int ef = (c >> wm) & ((1 << we) - 1);
    int bias = (1 << (we - 1)) - 1 + int'(n);
    if (c == 8'h00) return "R1";
    if (c == 8'h80) return n ? "R2" : "R3";
    if (!n && ef == (1 << we) - 1) return "R4";
    if (we == 5 && !n && !s32) return "R5";
    if (!s32 && (ef == 0 || ef - bias < -14)) return "R7";
    if (ef == 0) return "R6";
    return s32 ? "R8" : "R8/R9";
  endfunction

  task automatic drive(input logic [7:0] c, input logic n, input logic s32);
    item_t it;
    @(posedge clk);
    code <= c; nz <= n; sgl <= s32;
    it.code = c; it.nz = n; it.sgl = s32;
    it.exp_a = ref_model(4, c, n, s32);
    it.exp_b = ref_model(5, c, n, s32);
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        n_tests += 2;
        if (res_a !== it.exp_a) begin
          n_fail++;
          $display("FAIL %s WE=4 code=%02h nz=%0b s32=%0b actual=%08h expected=%08h",
                   tag(4, it.code, it.nz, it.sgl), it.code, it.nz, it.sgl, res_a, it.exp_a);
        end
        if (res_b !== it.exp_b) begin
          n_fail++;
          $display("FAIL %s WE=5 code=%02h nz=%0b s32=%0b actual=%08h expected=%08h",
                   tag(5, it.code, it.nz, it.sgl), it.code, it.nz, it.sgl, res_b, it.exp_b);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rst <= 0;
    drive(8'h00, 1'b0, 1'b0);
    drive(8'h00, 1'b1, 1'b1);
    drive(8'h80, 1'b1, 1'b0);
    drive(8'h80, 1'b0, 1'b1);
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 256; c++)
        drive(8'(c), m[0], m[1]);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule